// File: doc/BRIEF.md
# Display Event Interrupt Collector

This block gathers single-cycle event pulses from a display controller into sticky status bits and drives one level-sensitive interrupt line toward the processor. Software sees two views of the collected events. The raw view shows every captured event whatever the mask holds. The filtered view shows only the events whose enable bit is set.

Software never writes the enable mask directly. One register turns enables on for each 1 bit written to it, and a second register turns them off the same way. To acknowledge events, software reads the filtered view and writes the same value back, which clears exactly those bits. When servicing is complete, software writes the service-done register. Only after that write can the interrupt line assert again.

Eight event sources are implemented, at fixed bit positions that software decodes: 0 frame complete, 1 raster stopped, 2 sync lost, 3 bias-toggle count reached, 5 fifo underrun, 6 palette fetched, 8 buffer A finished, 9 buffer B finished. Bits 4 and 7 are reserved. The register port uses word offsets: 0 raw view, 1 filtered view (write 1 to clear), 2 enable-on, 3 enable-off, 4 service-done. Reads take effect in the same cycle; writes take effect at the clock edge.

Top module: `disp_irq_unit`

## Requirements
- R1: After reset, every status bit and every enable bit reads 0, and `irq_o` is low.
- R2: A pulse on an event input at bit 0, 1, 2, 3, 5, 6, 8 or 9 sets that status bit at the next clock edge, and the bit stays set until it is cleared. Bits 4 and 7 always read 0.
- R3: Reading offset 0 returns the status bits whatever the enables hold. Reading offset 1 returns the status bits ANDed with the enable mask.
- R4: Writing offset 2 sets every enable bit where the written value holds a 1 and leaves the other enable bits alone. Reading offset 2 returns the mask.
- R5: Writing offset 3 clears every enable bit where the written value holds a 1 and leaves the other enable bits alone. Reading offset 3 returns the mask.
- R6: Writing offset 1 clears the status bits where the written value holds a 1. Zero bits leave status unchanged. A write to offset 0 changes nothing.
- R7: When an event pulse and a clearing write at offset 1 hit the same bit in the same cycle, the bit ends up set.
- R8: When the filtered status is nonzero, `irq_o` is high one cycle later. Once high, `irq_o` stays high until a write to offset 4.
- R9: A write to offset 4 drives `irq_o` low for the next cycle. If filtered status is still nonzero in that low cycle, `irq_o` rises again in the cycle after. If it is not, `irq_o` stays low until an enabled event becomes pending.
- R10: Events whose enable bit is clear never raise `irq_o`. Reads of offsets 4 through 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 10 | Single-cycle event pulses, one per bit position |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word offset for both read and write |
| wdata_i | input | 10 | Write data |
| rdata_o | output | 10 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong sticky or mask bit shows up right away: reading the raw or filtered offset returns it in the same cycle. One cycle later it also shows up at `irq_o`, as a line that rises without cause or one that fails to rise. A lost or stuck end-of-service state shows at `irq_o` in the two cycles after the service-done write. There the line must drop for exactly one cycle, then either come back or stay low, depending on whether an enabled event is pending. Randomly ordered mask writes, acknowledges and event bursts are compared every cycle against a model in the bench. This model exposes a bad mask update within one cycle.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  localparam int EVT_W = 10;

  // Implemented event bits; 4 and 7 are reserved.
  localparam logic [EVT_W-1:0] EVT_IMPL = 10'b11_0110_1111;

  typedef enum logic [2:0] {
    OFS_RAW     = 3'd0,
    OFS_FILT    = 3'd1,
    OFS_EN_ON   = 3'd2,
    OFS_EN_OFF  = 3'd3,
    OFS_SVC_END = 3'd4
  } reg_ofs_e;

  // An arriving event outranks a clear of the same bit.
  function automatic logic [EVT_W-1:0] sticky_upd(
    input logic [EVT_W-1:0] cur,
    input logic [EVT_W-1:0] hit,
    input logic [EVT_W-1:0] wipe
  );
    return ((cur & ~wipe) | hit) & EVT_IMPL;
  endfunction

  function automatic logic [EVT_W-1:0] mask_upd(
    input logic [EVT_W-1:0] cur,
    input logic [EVT_W-1:0] on_bits,
    input logic [EVT_W-1:0] off_bits
  );
    return ((cur | on_bits) & ~off_bits) & EVT_IMPL;
  endfunction

  function automatic logic line_upd(
    input logic cur,
    input logic pend,
    input logic svc_end
  );
    return !svc_end && (cur || pend);
  endfunction

endpackage

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] wipe_i,
  output logic [EVT_W-1:0] status_o
);

  logic [EVT_W-1:0] nxt;

  always_comb nxt = sticky_upd(status_o, evt_i, wipe_i);

  for (genvar b = 0; b < EVT_W; b++) begin : g_bit
    if (EVT_IMPL[b]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) status_o[b] <= 1'b0;
        else        status_o[b] <= nxt[b];
      end
    end else begin : g_tie
      assign status_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/disp_irq_enable.sv
module disp_irq_enable
  import disp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] on_i,
  input  logic [EVT_W-1:0] off_i,
  output logic [EVT_W-1:0] mask_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_o <= '0;
    else        mask_o <= mask_upd(mask_o, on_i, off_i);
  end

endmodule

// File: rtl/disp_irq_line.sv
module disp_irq_line
  import disp_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic svc_end_i,
  output logic irq_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= line_upd(irq_o, pend_i, svc_end_i);
  end

endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
  import disp_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EVT_W-1:0]  wdata_i,
  output logic [EVT_W-1:0]  rdata_o,
  output logic              irq_o
);

  logic             hit_raw, hit_filt, hit_on, hit_off, hit_svc;
  logic [EVT_W-1:0] wipe_bits, on_bits, off_bits;
  logic [EVT_W-1:0] status_q, mask_q, filt;
  logic             svc_wr, pending;

  assign hit_raw  = (addr_i == ADDR_W'(OFS_RAW));
  assign hit_filt = (addr_i == ADDR_W'(OFS_FILT));
  assign hit_on   = (addr_i == ADDR_W'(OFS_EN_ON));
  assign hit_off  = (addr_i == ADDR_W'(OFS_EN_OFF));
  assign hit_svc  = (addr_i == ADDR_W'(OFS_SVC_END));

  assign wipe_bits = (wr_en_i && hit_filt) ? wdata_i : '0;
  assign on_bits   = (wr_en_i && hit_on)   ? wdata_i : '0;
  assign off_bits  = (wr_en_i && hit_off)  ? wdata_i : '0;
  assign svc_wr    = wr_en_i && hit_svc;

  disp_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wipe_i(wipe_bits), .status_o(status_q)
  );

  disp_irq_enable u_enable (
    .clk(clk), .rst_n(rst_n), .on_i(on_bits), .off_i(off_bits), .mask_o(mask_q)
  );

  assign filt    = status_q & mask_q;
  assign pending = |filt;

  disp_irq_line u_line (
    .clk(clk), .rst_n(rst_n), .pend_i(pending), .svc_end_i(svc_wr), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_raw)                rdata_o = status_q;
    else if (hit_filt)          rdata_o = filt;
    else if (hit_on || hit_off) rdata_o = mask_q;
  end

endmodule

// File: rtl/disp_irq_chk.sv
module disp_irq_chk
  import disp_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [EVT_W-1:0] evt_i,
  input logic [EVT_W-1:0] status_q,
  input logic [EVT_W-1:0] mask_q,
  input logic [EVT_W-1:0] on_bits,
  input logic [EVT_W-1:0] off_bits,
  input logic             svc_wr,
  input logic             pending,
  input logic             irq_o
);

  // R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ($past(evt_i) & EVT_IMPL)) == ($past(evt_i) & EVT_IMPL)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~EVT_IMPL) == '0);

  // R4
  en_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_bits != '0) |=> ((mask_q & ($past(on_bits) & EVT_IMPL)) == ($past(on_bits) & EVT_IMPL)));

  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_bits != '0) |=> ((mask_q & $past(off_bits)) == '0));

  // R9
  svc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_wr |=> !irq_o);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !svc_wr) |=> irq_o);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !svc_wr) |=> irq_o);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !pending) |=> !irq_o);

endmodule

bind disp_irq_unit disp_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .status_q(status_q), .mask_q(mask_q),
  .on_bits(on_bits), .off_bits(off_bits), .svc_wr(svc_wr), .pending(pending), .irq_o(irq_o)
);

// File: tb/disp_irq_unit_tb.sv
module disp_irq_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] IMPL = 10'b11_0110_1111;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] evt = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  logic [9:0] m_stat = '0;
  logic [9:0] m_en = '0;
  logic       m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_irq_unit #(.ADDR_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // Bit-by-bit restatement of the requirements
  function automatic logic [9:0] mdl_stat(logic [9:0] s, logic [9:0] e, logic [9:0] c);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = IMPL[i] && (e[i] || (s[i] && !c[i]));
    return r;
  endfunction

  function automatic logic [9:0] mdl_en(logic [9:0] m, logic [9:0] on, logic [9:0] off);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[i] = IMPL[i] && !off[i] && (on[i] || m[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] ev, input logic we, input logic [2:0] a,
                      input logic [9:0] wd);
    logic pend;
    @(negedge clk);
    evt = ev; wr_en = we; addr = a; wdata = wd;
    @(posedge clk);
    pend  = (m_stat & m_en) != 0;
    m_irq = (we && a == 3'd4) ? 1'b0 : (m_irq || pend);
    m_stat = mdl_stat(m_stat, ev, (we && a == 3'd1) ? wd : 10'h0);
    m_en   = mdl_en(m_en, (we && a == 3'd2) ? wd : 10'h0, (we && a == 3'd3) ? wd : 10'h0);
    #1;
    evt = '0; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [9:0] exp, input string req);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic check_all();
    check("R8 irq", {9'h0, irq}, {9'h0, m_irq});
    rd(3'd0, m_stat, "R2 raw");
    rd(3'd1, m_stat & m_en, "R3 filtered");
    rd(3'd2, m_en, "R4 enable read");
    rd(3'd3, m_en, "R5 enable read");
    rd(3'd5, 10'h0, "R10 unused offset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", {9'h0, irq}, 10'h0);
    rd(3'd0, 10'h0, "R1 raw");
    rd(3'd2, 10'h0, "R1 enable");

    // R2 all inputs pulsed, reserved bits stay zero; R10 no enables -> no irq
    step(10'h3FF, 1'b0, 3'd0, 10'h0);
    rd(3'd0, IMPL, "R2 implemented bits only");
    step(10'h0, 1'b0, 3'd0, 10'h0);
    step(10'h0, 1'b0, 3'd0, 10'h0);
    check("R10 disabled no irq", {9'h0, irq}, 10'h0);
    rd(3'd4, 10'h0, "R10 service offset reads zero");

    // R6 write to raw ignored
    step(10'h0, 1'b1, 3'd0, 10'h3FF);
    rd(3'd0, IMPL, "R6 raw write ignored");

    // R4 enable on bit 0 only, others unchanged
    step(10'h0, 1'b1, 3'd2, 10'h001);
    rd(3'd2, 10'h001, "R4 enable on");
    check("R8 not yet high", {9'h0, irq}, 10'h0);
    step(10'h0, 1'b0, 3'd0, 10'h0);
    check("R8 irq rises", {9'h0, irq}, 10'h1);

    // R6 clear bit 0 via filtered write; zero bits keep others
    step(10'h0, 1'b1, 3'd1, 10'h001);
    rd(3'd0, IMPL & ~10'h001, "R6 clear one bit");
    check("R8 irq held until service end", {9'h0, irq}, 10'h1);

    // R9 service end with nothing pending -> stays low
    step(10'h0, 1'b1, 3'd4, 10'h0);
    check("R9 drop", {9'h0, irq}, 10'h0);
    step(10'h0, 1'b0, 3'd0, 10'h0);
    check("R9 stays low", {9'h0, irq}, 10'h0);

    // R7 event and clear collide on bit 0
    step(10'h001, 1'b1, 3'd1, 10'h001);
    rd(3'd0, IMPL, "R7 event wins");

    // R9 service end while pending -> low one cycle, then high
    step(10'h0, 1'b0, 3'd0, 10'h0);
    check("R8 high again", {9'h0, irq}, 10'h1);
    step(10'h0, 1'b1, 3'd4, 10'h0);
    check("R9 low after service", {9'h0, irq}, 10'h0);
    step(10'h0, 1'b0, 3'd0, 10'h0);
    check("R9 reasserts", {9'h0, irq}, 10'h1);

    // R5 disable bit 0, mask empty
    step(10'h0, 1'b1, 3'd3, 10'h3FF);
    rd(3'd3, 10'h0, "R5 enable off");
    rd(3'd1, 10'h0, "R3 filtered empty");
    step(10'h0, 1'b1, 3'd4, 10'h0);
    step(10'h0, 1'b0, 3'd0, 10'h0);
    check("R10 masked pending stays quiet", {9'h0, irq}, 10'h0);
    check_all();

    // Random phase
    for (int n = 0; n < 600; n++) begin
      logic [9:0] ev;
      logic [2:0] a;
      logic       we;
      ev = ($urandom % 4 == 0) ? 10'($urandom) : 10'h0;
      a  = 3'($urandom % 6);
      we = ($urandom % 3) != 0;
      if (a == 3'd1 && ($urandom % 2) == 0) step(ev, we, a, m_stat & m_en);
      else step(ev, we, a, 10'($urandom));
      check_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule